// File: doc/BRIEF.md
# Programmable Parallel-Port Byte Transmitter

This block sends bytes to a peripheral over a Centronics-style parallel port, one direction only (host to peripheral). Bytes come in on a valid/ready stream, typically from a DMA FIFO. For each byte the block drives the data pins and waits a programmed number of clocks. It then pulls the active-low strobe down for a programmed width. Finally it completes the handshake the configuration asks for: acknowledge, busy, both, or neither. Every delay is counted in cycles of the block's own clock.

The stream follows the usual valid/ready rules. A byte moves only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle and allowed to start a byte. The source may hold `in_valid` high for any number of cycles and must keep `in_data` stable until the transfer. Back-pressure lasts through the whole setup, strobe and handshake of the current byte, and also while a busy peripheral, an error, the reverse direction or a cleared run bit blocks new work.

Control inputs are plain levels. The configuration is expected to stay static while a byte is in flight, except for the run bit. `ack_n` and `busy` are synchronised inside the block.

Top module: `lpt_xmit`

## Requirements
- R1: A byte is accepted only when `cfg_run`=1, `cfg_reverse`=0, `hs_err`=0 and no earlier byte is still in flight. While `in_ready` is high the strobe is released (`strobe_n`=1). Every accepted byte produces exactly one strobe pulse.
- R2: While `cfg_reverse`=1, `in_ready` stays low and no strobe pulse starts, whatever `in_valid` does.
- R3: `strobe_n` falls exactly `cfg_setup` clocks after the clock edge that loads the byte onto `pd_out`. The range is 0 to 127, and 0 means strobe and data change on the same edge.
- R4: `strobe_n` stays low for exactly `cfg_strobe` clocks when `cfg_strobe` is 4 or more. For any setting from 0 to 3 it stays low for exactly 4 clocks.
- R5: `pd_out` holds the accepted byte unchanged from the loading edge through the end of the strobe and handshake.
- R6: With `cfg_use_busy`=1, no byte is accepted while the synchronised `busy` input is high.
- R7: With `cfg_use_ack`=1, after the strobe the block accepts no new byte until it sees a falling edge on `ack_n`. That edge may arrive during the strobe itself.
- R8: With both handshake modes off, `in_ready` is high again in the first cycle after `strobe_n` rises, provided R1's conditions hold.
- R9: With `cfg_timeout`=T (T≠0), if a handshake wait (acknowledge wait, or busy stall with a byte pending) lasts T cycles, `hs_err` sets. The strobe is left released. `hs_err` stays set, and `in_ready` stays low, until a cycle with `err_clr`=1. T=0 disables the timeout.
- R10: Clearing `cfg_run` while a byte is in flight does not cut that byte short. Its strobe completes, and then `in_ready` stays low.
- R11: `oe_strobe`, `oe_ack` and `oe_busy` follow `cfg_oe` bits 0, 1 and 2 with one clock of delay.
- R12: After reset, `strobe_n`=1, `in_ready`=0, `hs_err`=0 and `pd_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_run | input | 1 | Enables transfers |
| cfg_reverse | input | 1 | Direction; 1 blocks all transfers |
| cfg_setup | input | TW (7) | Clocks from data load to strobe |
| cfg_strobe | input | TW (7) | Strobe width in clocks (0..3 give 4) |
| cfg_use_ack | input | 1 | Wait for acknowledge pulse |
| cfg_use_busy | input | 1 | Hold off new bytes while busy |
| cfg_timeout | input | TOW (16) | Handshake timeout in clocks, 0 = off |
| cfg_oe | input | 3 | Output enables: strobe, ack, busy |
| err_clr | input | 1 | Clears the sticky timeout flag |
| in_valid | input | 1 | Stream byte available |
| in_ready | output | 1 | Block takes the byte this cycle |
| in_data | input | DW (8) | Stream byte |
| pd_out | output | DW (8) | Parallel data pins |
| strobe_n | output | 1 | Active-low data strobe |
| ack_n | input | 1 | Active-low acknowledge from peripheral |
| busy | input | 1 | Busy from peripheral |
| oe_strobe | output | 1 | Pad enable for strobe |
| oe_ack | output | 1 | Pad enable for acknowledge |
| oe_busy | output | 1 | Pad enable for busy |
| hs_err | output | 1 | Sticky handshake timeout flag |

## Verification
The bound checker checks several rules on every cycle. Ready never coexists with an asserted strobe, a direction-blocked port, a raised error flag, or busy held long enough to pass the synchroniser. The error flag never drops without a clear. Every strobe pulse is at least four clocks wide, exactly the programmed width when that is 4 or more, and the data never moves while the strobe is low. The exact setup delay, the pairing of each accepted byte with its strobe, the wait for an acknowledge edge, the finish of a byte after the run bit is cleared, and the timeout recovery all depend on a sequence of stimulus. Only the bench's scenarios show these.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_ACKW   = 2'd3
  } lpt_state_e;

  // shortest strobe the port ever produces, in clocks
  localparam int unsigned LPT_MIN_STROBE = 4;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int unsigned N       = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lpt_phase_cnt.sv
module lpt_phase_cnt #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/lpt_wdog.sv
module lpt_wdog #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         waiting,
  input  logic [W-1:0] limit,
  input  logic         clr,
  output logic         trip,
  output logic         err
);
  logic [W-1:0] cnt_q;

  assign trip = waiting && (limit != '0) && (cnt_q == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!waiting) cnt_q <= '0;
    else if (cnt_q != '1) cnt_q <= cnt_q + W'(1);
  end

  // a trip in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else if (trip) err <= 1'b1;
    else if (clr) err <= 1'b0;
  end
endmodule

// File: rtl/lpt_xmit.sv
module lpt_xmit
  import lpt_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned TW          = 7,
  parameter int unsigned TOW         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_run,
  input  logic          cfg_reverse,
  input  logic [TW-1:0] cfg_setup,
  input  logic [TW-1:0] cfg_strobe,
  input  logic          cfg_use_ack,
  input  logic          cfg_use_busy,
  input  logic [TOW-1:0] cfg_timeout,
  input  logic [2:0]    cfg_oe,
  input  logic          err_clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] pd_out,
  output logic          strobe_n,
  input  logic          ack_n,
  input  logic          busy,
  output logic          oe_strobe,
  output logic          oe_ack,
  output logic          oe_busy,
  output logic          hs_err
);
  localparam logic [TW-1:0] MIN_W = TW'(LPT_MIN_STROBE);

  lpt_state_e state_q, state_d;
  logic ack_s, busy_s, ack_prev, ack_fall, ack_seen;
  logic busy_block, allowed, take;
  logic ph_load, ph_zero;
  logic [TW-1:0] ph_val, stb_len;
  logic wd_wait, wd_trip;

  lpt_sync #(.N(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({busy, ack_n}), .q({busy_s, ack_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_prev <= 1'b1;
    else ack_prev <= ack_s;
  end
  assign ack_fall = ack_prev & ~ack_s;

  assign busy_block = cfg_use_busy & busy_s;
  assign allowed    = cfg_run & ~cfg_reverse & ~hs_err;
  assign in_ready   = (state_q == ST_IDLE) & allowed & ~busy_block;
  assign take       = in_ready & in_valid;
  assign stb_len    = (cfg_strobe < MIN_W) ? MIN_W : cfg_strobe;

  lpt_phase_cnt #(.W(TW)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  assign wd_wait = (state_q == ST_ACKW) |
                   ((state_q == ST_IDLE) & allowed & busy_block & in_valid);

  lpt_wdog #(.W(TOW)) u_wdog (
    .clk(clk), .rst_n(rst_n), .waiting(wd_wait), .limit(cfg_timeout),
    .clr(err_clr), .trip(wd_trip), .err(hs_err)
  );

  always_comb begin
    state_d = state_q;
    ph_load = 1'b0;
    ph_val  = stb_len - TW'(1);
    unique case (state_q)
      ST_IDLE: if (take) begin
        ph_load = 1'b1;
        if (cfg_setup == '0) begin
          state_d = ST_STROBE;
        end else begin
          state_d = ST_SETUP;
          ph_val  = cfg_setup - TW'(1);
        end
      end
      ST_SETUP: if (ph_zero) begin
        state_d = ST_STROBE;
        ph_load = 1'b1;
      end
      ST_STROBE: if (ph_zero) begin
        if (cfg_use_ack && !ack_seen && !ack_fall) state_d = ST_ACKW;
        else state_d = ST_IDLE;
      end
      ST_ACKW: if (ack_fall || wd_trip) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pd_out   <= '0;
      ack_seen <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) begin
        pd_out   <= in_data;
        ack_seen <= 1'b0;
      end else if (ack_fall && (state_q == ST_STROBE || state_q == ST_ACKW)) begin
        ack_seen <= 1'b1;
      end
    end
  end

  assign strobe_n = (state_q != ST_STROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {oe_busy, oe_ack, oe_strobe} <= 3'b000;
    else {oe_busy, oe_ack, oe_strobe} <= cfg_oe;
  end
endmodule

// File: rtl/lpt_xmit_chk.sv
module lpt_xmit_chk #(
  parameter int unsigned DW          = 8,
  parameter int unsigned TW          = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_reverse,
  input logic [TW-1:0] cfg_strobe,
  input logic          cfg_use_busy,
  input logic          busy,
  input logic          err_clr,
  input logic          in_ready,
  input logic          strobe_n,
  input logic [DW-1:0] pd_out,
  input logic          hs_err
);
  logic [7:0] low_cnt, busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      busy_cnt <= '0;
    end else begin
      if (strobe_n) low_cnt <= '0;
      else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 8'd1;
      if (!busy) busy_cnt <= '0;
      else if (busy_cnt != 8'hFF) busy_cnt <= busy_cnt + 8'd1;
    end
  end

  p_ready_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> strobe_n);

  p_reverse_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reverse |-> !in_ready);

  p_strobe_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n) |-> (low_cnt >= 8'd4));

  p_strobe_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(strobe_n) && cfg_strobe >= TW'(4)) |-> (low_cnt == 8'(cfg_strobe)));

  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && !$past(strobe_n)) |-> $stable(pd_out));

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_use_busy && busy_cnt > 8'(SYNC_STAGES)) |-> !in_ready);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_err && !err_clr) |=> hs_err);

  p_err_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hs_err |-> !in_ready);
endmodule

bind lpt_xmit lpt_xmit_chk #(.DW(DW), .TW(TW), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_reverse(cfg_reverse), .cfg_strobe(cfg_strobe),
  .cfg_use_busy(cfg_use_busy), .busy(busy), .err_clr(err_clr),
  .in_ready(in_ready), .strobe_n(strobe_n), .pd_out(pd_out), .hs_err(hs_err)
);

// File: tb/lpt_xmit_bench.sv
module lpt_xmit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_run = 0, cfg_reverse = 0, cfg_use_ack = 0, cfg_use_busy = 0;
  logic [6:0] cfg_setup = 0, cfg_strobe = 0;
  logic [15:0] cfg_timeout = 0;
  logic [2:0] cfg_oe = 0;
  logic err_clr = 0, in_valid = 0, ack_n = 1, busy = 0;
  logic [7:0] in_data = 0;
  logic in_ready, strobe_n, oe_strobe, oe_ack, oe_busy, hs_err;
  logic [7:0] pd_out;

  int n_checks = 0, n_fail = 0, n_strobes = 0, since_acc = 0, low_cnt = 0, snap = 0;
  logic prev_stb = 1'b1;
  logic [7:0] cur = 0;
  logic [7:0] exp_q [$];
  bit ack_auto = 0, ack_req = 0, done = 0;

  always #4 clk = ~clk;

  lpt_xmit u_lpt_xmit (
    .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_reverse(cfg_reverse),
    .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_use_ack(cfg_use_ack),
    .cfg_use_busy(cfg_use_busy), .cfg_timeout(cfg_timeout), .cfg_oe(cfg_oe),
    .err_clr(err_clr), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .pd_out(pd_out), .strobe_n(strobe_n), .ack_n(ack_n), .busy(busy),
    .oe_strobe(oe_strobe), .oe_ack(oe_ack), .oe_busy(oe_busy), .hs_err(hs_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: queue the expectation, offer the byte until taken
  task automatic send(input logic [7:0] b);
    exp_q.push_back(b);
    in_data  = b;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_stb = 1'b1;
    end else begin
      if (in_valid && in_ready) since_acc = 0;
      else since_acc++;
      if (prev_stb && !strobe_n) begin
        n_strobes++;
        if (exp_q.size() == 0) begin
          chk(0, "R1 strobe without byte", 1, 0);
        end else begin
          cur = exp_q.pop_front();
          chk(pd_out == cur, "R5 data at strobe", pd_out, cur);
          chk(since_acc == int'(cfg_setup) + 1, "R3 setup clocks", since_acc - 1, cfg_setup);
        end
        low_cnt = 1;
        ack_req = 1;
      end else if (!strobe_n) begin
        low_cnt++;
      end
      if (!prev_stb && strobe_n) begin
        chk(low_cnt == ((cfg_strobe < 4) ? 4 : int'(cfg_strobe)), "R4 strobe width",
            low_cnt, (cfg_strobe < 4) ? 4 : cfg_strobe);
        chk(pd_out == cur, "R5 data held", pd_out, cur);
        if (!cfg_use_ack && !cfg_use_busy && cfg_run && !cfg_reverse && !hs_err)
          chk(in_ready == 1'b1, "R8 ready after strobe", in_ready, 1);
      end
      prev_stb = strobe_n;
    end
  end

  // peripheral model: acknowledge pulse shortly after each strobe
  initial forever begin
    @(negedge clk);
    if (ack_auto && ack_req) begin
      ack_req = 0;
      cyc(2);
      ack_n = 1'b0;
      cyc(2);
      ack_n = 1'b1;
    end else if (!ack_auto) begin
      ack_req = 0;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(strobe_n == 1'b1, "R12 strobe released", strobe_n, 1);
    chk(in_ready == 1'b0, "R12 not ready", in_ready, 0);
    chk(hs_err == 1'b0, "R12 no error", hs_err, 0);
    chk(pd_out == 8'h00, "R12 data cleared", pd_out, 0);

    // R1: run off blocks
    cyc(1);
    in_valid = 1'b1; in_data = 8'h77;
    cyc(20);
    @(negedge clk);
    chk(in_ready == 1'b0 && n_strobes == 0, "R1 run off", in_ready, 0);
    cyc(1);
    in_valid = 1'b0;

    // plain mode, several timings (R3, R4, R8)
    cfg_run = 1; cfg_setup = 3; cfg_strobe = 6;
    send(8'hA5); send(8'h3C); send(8'hFF);
    cyc(20);
    cfg_setup = 0; cfg_strobe = 0;
    send(8'h01); send(8'h80);
    cyc(12);
    cfg_strobe = 2; send(8'h55); cyc(12);
    cfg_strobe = 3; cfg_setup = 1; send(8'hAA); cyc(12);
    cfg_strobe = 4; send(8'h0F); cyc(12);
    cfg_setup = 127; cfg_strobe = 127;
    send(8'hC3);
    cyc(270);
    chk(n_strobes == 9, "R1 one strobe per byte", n_strobes, 9);

    // R11
    cfg_setup = 2; cfg_strobe = 5;
    cfg_oe = 3'b101;
    cyc(2);
    @(negedge clk);
    chk({oe_busy, oe_ack, oe_strobe} == 3'b101, "R11 output enables",
        {oe_busy, oe_ack, oe_strobe}, 5);

    // R2
    cyc(1);
    cfg_reverse = 1; in_valid = 1'b1; in_data = 8'h66;
    snap = n_strobes;
    cyc(40);
    @(negedge clk);
    chk(in_ready == 1'b0 && n_strobes == snap, "R2 reverse blocks", n_strobes, snap);
    cyc(1);
    in_valid = 1'b0;
    cyc(1);
    cfg_reverse = 0;

    // R6 busy hold-off
    cfg_use_busy = 1; busy = 1;
    cyc(4);
    snap = n_strobes;
    fork send(8'h11); join_none
    cyc(30);
    @(negedge clk);
    chk(in_ready == 1'b0 && n_strobes == snap, "R6 busy holds", n_strobes, snap);
    cyc(1);
    busy = 0;
    cyc(20);
    chk(n_strobes == snap + 1, "R6 sent after busy", n_strobes, snap + 1);
    cfg_use_busy = 0;

    // R7 acknowledge wait
    cfg_use_ack = 1;
    snap = n_strobes;
    send(8'h42);
    cyc(40);
    @(negedge clk);
    chk(in_ready == 1'b0 && n_strobes == snap + 1, "R7 waiting for ack", in_ready, 0);
    cyc(1);
    ack_n = 1'b0; cyc(3); ack_n = 1'b1;
    cyc(8);
    @(negedge clk);
    chk(in_ready == 1'b1, "R7 ready after ack", in_ready, 1);
    cyc(1);
    ack_auto = 1;
    send(8'h21); send(8'h43); send(8'h87);
    cyc(20);
    cfg_use_busy = 1; cfg_strobe = 20;
    send(8'h9C); send(8'hE1);
    cyc(40);
    chk(n_strobes == snap + 6, "R7 acked bytes", n_strobes, snap + 6);
    cfg_use_busy = 0; cfg_strobe = 5;

    // R9 timeout
    ack_auto = 0; cfg_timeout = 20;
    send(8'h99);
    cyc(60);
    @(negedge clk);
    chk(hs_err == 1'b1, "R9 error set", hs_err, 1);
    chk(in_ready == 1'b0 && strobe_n == 1'b1, "R9 blocked and released", in_ready, 0);
    cyc(10);
    @(negedge clk);
    chk(hs_err == 1'b1, "R9 error sticky", hs_err, 1);
    cyc(1);
    err_clr = 1; cyc(1); err_clr = 0;
    @(negedge clk);
    chk(hs_err == 1'b0 && in_ready == 1'b1, "R9 cleared", hs_err, 0);
    cyc(1);
    ack_auto = 1;
    send(8'h5A);
    cyc(30);
    chk(hs_err == 1'b0, "R9 no error on acked byte", hs_err, 0);

    // R10 run cleared mid-byte
    ack_auto = 0; cfg_use_ack = 0; cfg_timeout = 0; cfg_setup = 40; cfg_strobe = 4;
    snap = n_strobes;
    send(8'h3E);
    cyc(5);
    cfg_run = 0;
    cyc(100);
    @(negedge clk);
    chk(n_strobes == snap + 1, "R10 byte finished", n_strobes, snap + 1);
    chk(in_ready == 1'b0, "R10 idle after run off", in_ready, 0);
    chk(exp_q.size() == 0, "R1 all bytes strobed", exp_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule